// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse-Width Modulator

This block produces four independent pulse-width modulated outputs from a single work clock. Software programs each channel through a small memory-mapped port with a byte address, a write strobe, write data and combinational read data. Each channel has three registers. The control word holds the enable, the polarity and a 10-bit clock divider. The second register holds the cycle length and the third holds the active time. Both lengths are counted in prescaled ticks.

A channel's period counter advances once every `divider` work-clock cycles. The channel is in its active phase while the count is below the active-time value. The polarity bit decides whether the active phase drives the pin high or low. Before changing the divider or either length, software clears the enable bit. That parks the pin at its inactive level and rewinds the counters, so the new setting starts cleanly from count zero when the channel is enabled again.

Top module: `pwm_bank`

## Requirements
- R1: Channel n (n = 0..3) occupies bytes (n+1)*0x10 onward: control word at +0x0, period at +0x4, active time at +0x8. A read returns the last value written, masked to 12 bits for the control word and 16 bits for period and active time, with all upper bits zero. Read data is valid in the same cycle as the address.
- R2: In the control word, bit 0 enables the channel, bit 1 selects polarity, and bits 11:2 hold the divider.
- R3: With divider D, the period count advances once every D work-clock cycles. A divider of 0 behaves as 1.
- R4: With period P and active time A, where 0 < A < P, the count runs 0..P-1 and the output repeats every P*D cycles. It is in the active phase for exactly A*D of those cycles, starting at count 0.
- R5: When the active time is greater than or equal to the period, the output stays in the active phase. When the active time is 0, the output never enters it.
- R6: When the polarity bit is 1, the active phase drives the output high. When it is 0, the output is inverted, so the active phase drives it low.
- R7: A write that clears enable takes effect at the edge that captures it. From the next cycle the output sits at its inactive level (0 for polarity 1, 1 for polarity 0) and the counters are at zero. A write that sets enable starts the channel at count 0: if the active time is nonzero, the output is in its active phase in the first cycle after that edge.
- R8: Synchronous reset clears every register. After reset all four outputs are 1, which is the inactive level for polarity 0.
- R9: Addresses outside the twelve mapped registers, including offset +0xC within a bank and banks 0 and 5 and above, read as zero. Writes to them change nothing.
- R10: Each channel's output depends only on its own registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Work clock, also used for register access |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, captured on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 4 | One modulated output per channel |

## Verification
A write is captured at a rising edge, and the register, counters and output reflect it in the cycle after that edge. Read data follows the address within the same cycle. The bench's behavioural model applies each write at the same edge as the design. It compares every output and the read data 2 ns after each rising edge, after everything driven from that edge has settled and well before the inputs change at the falling edge. The directed checks count active cycles over whole periods, starting at the falling edge right after the enabling write. That edge falls in the first cycle in which the channel runs.

// File: rtl/pwm_bank_pkg.sv
// Package pwm_bank_pkg
// Shared widths, the register selector type and the in-bank offset decode
// used by the register file. Assumes word-aligned byte addresses.
package pwm_bank_pkg;

    localparam int DIV_W  = 10;          // prescaler field width
    localparam int CNT_W  = 16;          // period / active-time width
    localparam int MODE_W = DIV_W + 2;   // enable + polarity + divider

    localparam logic [3:0] OFS_MODE   = 4'h0;
    localparam logic [3:0] OFS_PERIOD = 4'h4;
    localparam logic [3:0] OFS_DUTY   = 4'h8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_PERIOD,
        SEL_DUTY
    } reg_sel_e;

    // Map the low address nibble to a register inside one bank.
    function automatic reg_sel_e sel_of(input logic [3:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_MODE:   s = SEL_MODE;
            OFS_PERIOD: s = SEL_PERIOD;
            OFS_DUTY:   s = SEL_DUTY;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
// Module pwm_regs
// Register file for all channels: address decode, write capture and
// combinational read-back. Bank n+1 (address bits above the low nibble)
// belongs to channel n; bank 0 and banks past the last channel are unmapped.
// Assumes a single clock and one access per cycle.
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                addr,
    input  logic                             we,
    input  logic [DATA_W-1:0]                wdata,
    output logic [DATA_W-1:0]                rdata,
    output logic [NUM_CH-1:0][MODE_W-1:0]    mode_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]     period_o,
    output logic [NUM_CH-1:0][CNT_W-1:0]     duty_o
);

    localparam int BANK_W = ADDR_W - 4;
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [BANK_W-1:0]               bank_idx;
    logic                            bank_hit;
    logic [CH_W-1:0]                 ch_idx;
    reg_sel_e                        sel;

    logic [NUM_CH-1:0][MODE_W-1:0]   mode_q;
    logic [NUM_CH-1:0][CNT_W-1:0]    period_q;
    logic [NUM_CH-1:0][CNT_W-1:0]    duty_q;

    // Decode the address into a channel index and a register selector.
    always_comb begin
        bank_idx = addr[ADDR_W-1:4];
        bank_hit = (bank_idx != '0) && (bank_idx <= BANK_W'(NUM_CH));
        ch_idx   = CH_W'(bank_idx - BANK_W'(1));
        sel      = bank_hit ? sel_of(addr[3:0]) : SEL_NONE;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
        logic hit_me;
        assign hit_me = we && (sel != SEL_NONE) && (ch_idx == CH_W'(g));

        // Capture writes addressed to this channel's bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q[g]   <= '0;
                period_q[g] <= '0;
                duty_q[g]   <= '0;
            end else if (hit_me) begin
                case (sel)
                    SEL_MODE:   mode_q[g]   <= wdata[MODE_W-1:0];
                    SEL_PERIOD: period_q[g] <= wdata[CNT_W-1:0];
                    SEL_DUTY:   duty_q[g]   <= wdata[CNT_W-1:0];
                    default:    ;
                endcase
            end
        end

        AST_PERIOD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == SEL_PERIOD && ch_idx == CH_W'(g))
            |=> (period_q[g] == $past(wdata[CNT_W-1:0]))); // R1
        AST_MODE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            (we && sel == SEL_MODE && ch_idx == CH_W'(g))
            |=> (mode_q[g] == $past(wdata[MODE_W-1:0]))); // R2
    end

    // Return the selected register, zero-extended; zero when unmapped.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_MODE:   rdata = DATA_W'(mode_q[ch_idx]);
            SEL_PERIOD: rdata = DATA_W'(period_q[ch_idx]);
            SEL_DUTY:   rdata = DATA_W'(duty_q[ch_idx]);
            default:    rdata = '0;
        endcase
    end

    assign mode_o   = mode_q;
    assign period_o = period_q;
    assign duty_o   = duty_q;

    AST_UNMAPPED_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_NONE)
        |=> ($stable(mode_q) && $stable(period_q) && $stable(duty_q))); // R9

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (rdata == '0)); // R9

endmodule

// File: rtl/pwm_channel.sv
// Module pwm_channel
// One modulator: a prescaler that divides the work clock by the divider
// field (0 treated as 1), a period counter that wraps at the programmed
// period, and the compare against the active time with polarity applied.
// Assumes software disables the channel before reprogramming it; a live
// change is tolerated (wrap uses >=) but is not glitch-free.
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    input  logic [CNT_W-1:0]  period,
    input  logic [CNT_W-1:0]  duty,
    output logic              pwm_o
);

    logic              en;
    logic              pol;
    logic [DIV_W-1:0]  div_raw;
    logic [DIV_W-1:0]  div_eff;
    logic [DIV_W-1:0]  presc_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W:0]    cnt_inc;
    logic              tick;
    logic              wrap;
    logic              active;

    // Split the control word and derive the effective divider.
    always_comb begin
        en      = mode[0];
        pol     = mode[1];
        div_raw = mode[MODE_W-1:2];
        div_eff = (div_raw == '0) ? DIV_W'(1) : div_raw;
        tick    = (presc_q >= (div_eff - DIV_W'(1)));
        cnt_inc = (CNT_W+1)'(cnt_q) + (CNT_W+1)'(1);
        wrap    = (cnt_inc >= {1'b0, period});
    end

    // Prescaler and period counter; both held at zero while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            presc_q <= '0;
            cnt_q   <= '0;
        end else if (tick) begin
            presc_q <= '0;
            cnt_q   <= wrap ? '0 : cnt_inc[CNT_W-1:0];
        end else begin
            presc_q <= presc_q + DIV_W'(1);
        end
    end

    // Active phase while the count is below the active time; apply polarity.
    always_comb begin
        active = en && (cnt_q < duty);
        pwm_o  = pol ? active : ~active;
    end

    AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> (cnt_q == '0 && presc_q == '0)); // R7

    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && !$past(tick)) |-> $stable(cnt_q)); // R3

    AST_TICK_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && $past(tick)) |-> (presc_q == '0)); // R3

endmodule

// File: rtl/pwm_bank.sv
// Module pwm_bank
// Top level: one register file and NUM_CH modulators. Single clock
// domain; register access and PWM counting share clk.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    logic [NUM_CH-1:0][MODE_W-1:0] mode_w;
    logic [NUM_CH-1:0][CNT_W-1:0]  period_w;
    logic [NUM_CH-1:0][CNT_W-1:0]  duty_w;

    pwm_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .mode_o   (mode_w),
        .period_o (period_w),
        .duty_o   (duty_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode   (mode_w[g]),
            .period (period_w[g]),
            .duty   (duty_w[g]),
            .pwm_o  (pwm_out[g])
        );

        AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (!mode_w[g][0]) |-> (pwm_out[g] == !mode_w[g][1])); // R7
    end

endmodule

// File: tb/pwm_bank_bench.sv
// Bench for pwm_bank: a behavioural per-channel model compared on every
// clock, plus directed width measurements and register checks.
module pwm_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    pwm_bank u_pwm_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    // ---------------- behavioural model ----------------
    int m_mode[4];
    int m_per[4];
    int m_duty[4];
    int m_pc[4];
    int m_cnt[4];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_mode[c] = 0; m_per[c] = 0; m_duty[c] = 0;
                m_pc[c] = 0; m_cnt[c] = 0;
            end
        end else begin
            for (int c = 0; c < 4; c++) begin
                int d;
                d = (m_mode[c] >> 2) & 1023;
                if (d == 0) d = 1;
                if ((m_mode[c] & 1) == 0) begin
                    m_pc[c] = 0; m_cnt[c] = 0;
                end else if (m_pc[c] >= d - 1) begin
                    m_pc[c] = 0;
                    m_cnt[c] = (m_cnt[c] + 1 >= m_per[c]) ? 0 : m_cnt[c] + 1;
                end else begin
                    m_pc[c] = m_pc[c] + 1;
                end
            end
            if (bus_we) begin
                int b, o;
                b = int'(bus_addr) >> 4;
                o = int'(bus_addr) & 15;
                if (b >= 1 && b <= 4) begin
                    if (o == 0) m_mode[b-1] = int'(bus_wdata) & 32'hFFF;
                    if (o == 4) m_per[b-1]  = int'(bus_wdata) & 32'hFFFF;
                    if (o == 8) m_duty[b-1] = int'(bus_wdata) & 32'hFFFF;
                end
            end
        end
    end

    function automatic logic model_out(int c);
        logic act;
        act = ((m_mode[c] & 1) != 0) && (m_cnt[c] < m_duty[c]);
        return ((m_mode[c] & 2) != 0) ? act : !act;
    endfunction

    function automatic logic [31:0] model_rd(logic [7:0] a);
        int b, o;
        b = int'(a) >> 4;
        o = int'(a) & 15;
        if (b < 1 || b > 4) return 32'h0;
        if (o == 0) return 32'(m_mode[b-1]);
        if (o == 4) return 32'(m_per[b-1]);
        if (o == 8) return 32'(m_duty[b-1]);
        return 32'h0;
    endfunction

    // Every-cycle comparison of all outputs and read data (R10 independence).
    always @(posedge clk) begin
        #2;
        if (!done) begin
            logic [3:0] eo;
            for (int c = 0; c < 4; c++) eo[c] = model_out(c);
            tests++;
            if (eo !== pwm_out) begin
                fails++;
                $display("FAIL R10 model pwm_out actual=%b expected=%b t=%0t", pwm_out, eo, $time);
            end
            tests++;
            if (model_rd(bus_addr) !== bus_rdata) begin
                fails++;
                $display("FAIL R1 model rdata addr=%h actual=%h expected=%h", bus_addr, bus_rdata, model_rd(bus_addr));
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, int'(bus_rdata), int'(exp));
    endtask

    // Count cycles in which channel ch sits at level lvl over n cycles.
    task automatic measure(input string req, input int ch, input logic lvl,
                           input int n, input int exp);
        int k = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out[ch] == lvl) k++;
            @(negedge clk);
        end
        check(req, k, exp);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state
        check("R8 reset outputs", int'(pwm_out), 4'hF);
        rd("R8 reset ch0 mode", 8'h10, 32'h0);
        rd("R8 reset ch3 duty", 8'h48, 32'h0);

        // Program all channels while disabled.
        wr(8'h10, 32'h0E); wr(8'h14, 32'd10); wr(8'h18, 32'd4);  // div3 pol1
        wr(8'h20, 32'h04); wr(8'h24, 32'd7);  wr(8'h28, 32'd3);  // div1 pol0
        wr(8'h30, 32'h02); wr(8'h34, 32'd5);  wr(8'h38, 32'd5);  // div0 pol1 full
        wr(8'h40, 32'h16); wr(8'h44, 32'd6);  wr(8'h48, 32'd0);  // div5 pol1 zero
        rd("R1 ch0 mode readback", 8'h10, 32'h0E);
        rd("R1 ch1 period readback", 8'h24, 32'd7);
        rd("R1 ch2 duty readback", 8'h38, 32'd5);
        check("R7 disabled pol0 idles high", int'(pwm_out[1]), 1);

        // R4 / R3: ch0, div 3, period 10, active 4 -> 12 of 30 cycles high
        wr(8'h10, 32'h0F);
        check("R7 first cycle active", int'(pwm_out[0]), 1);
        measure("R4 R3 ch0 high width", 0, 1'b1, 30, 12);
        measure("R4 ch0 second period", 0, 1'b1, 30, 12);

        // R6: ch1 inverted, div 1, period 7, active 3 -> 3 low cycles of 7
        wr(8'h20, 32'h05);
        measure("R6 ch1 low width inverted", 1, 1'b0, 7, 3);
        measure("R6 ch1 next period", 1, 1'b0, 14, 6);

        // R5 / R3: ch2 active >= period, divider 0 -> always high
        wr(8'h30, 32'h03);
        measure("R5 ch2 full active", 2, 1'b1, 20, 20);

        // R5: ch3 active 0 -> never high
        wr(8'h40, 32'h17);
        measure("R5 ch3 zero active", 3, 1'b1, 60, 0);

        // R7: disable, reconfigure, re-enable
        wr(8'h10, 32'h0E);
        check("R7 ch0 idle after disable", int'(pwm_out[0]), 0);
        wr(8'h20, 32'h04);
        check("R7 ch1 idle high after disable", int'(pwm_out[1]), 1);
        wr(8'h10, 32'h0A); wr(8'h14, 32'd8); wr(8'h18, 32'd6);
        check("R7 ch0 stays idle while reprogrammed", int'(pwm_out[0]), 0);
        wr(8'h10, 32'h0B);
        check("R7 ch0 restart active", int'(pwm_out[0]), 1);
        measure("R7 R4 ch0 new width", 0, 1'b1, 16, 12);

        // R9: unmapped writes and reads
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h50, 32'hFFFF_FFFF);
        rd("R9 bank0 reads zero", 8'h00, 32'h0);
        rd("R9 offset C reads zero", 8'h1C, 32'h0);
        rd("R9 bank5 reads zero", 8'h50, 32'h0);
        rd("R9 ch0 period untouched", 8'h14, 32'd8);
        rd("R9 ch0 duty untouched", 8'h18, 32'd6);
        rd("R9 ch0 mode untouched", 8'h10, 32'h0B);

        // R2 / R1: control word masked to 12 bits
        wr(8'h20, 32'hFFFF_FFFC);
        rd("R2 ch1 mode masked", 8'h20, 32'hFFC);
        wr(8'h24, 32'hABCD_1234);
        rd("R1 ch1 period masked", 8'h24, 32'h1234);
        wr(8'h20, 32'h04);

        repeat (200) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule